// File: doc/BRIEF.md
# Table-Driven Fixed-Coefficient Multiplier

This block multiplies a variable unsigned operand by a coefficient fixed at elaboration time. It has no general multiplier and no array of AND gates. The operand is cut into 4-bit digits. Each digit addresses its own small table, and every table holds the product of each possible digit value with the coefficient. The tables are filled from the coefficient parameter when the design elaborates. The table outputs are then shifted into place by their digit weight and summed, which gives the full-width product.

With the default sizes, the operand is 8 bits, the coefficient is 8 bits and the product is 16 bits. Two tables of 16 entries, each entry 12 bits wide, feed one 16-bit adder. A parameter places an optional register on the product. With the register the result appears one clock after the operand. Without it the product follows the operand in the same cycle. The block has no control states: it is a pure data path, apart from the optional register.

Top module: `lut_const_mult`

## Requirements
- R1: Operand bits [3:0] (the low digit) address the low table, and that table's entry enters the sum with no shift. An operand whose bits [7:4] are zero yields exactly operand×COEF.
- R2: Operand bits [7:4] (the high digit) address the high table, and that table's entry enters the sum shifted left by 4. An operand whose bits [3:0] are zero yields (operand[7:4]×COEF)<<4.
- R3: Each table entry at index n equals n×COEF, held in 12 bits, so no entry exceeds 15×COEF.
- R4: For every one of the 256 operand values the 16-bit product equals operand×COEF. This holds for any 8-bit COEF.
- R5: With REG_OUT=1 the product for an operand presented before a rising clock edge appears at product_o after that edge and holds until the next edge.
- R6: With REG_OUT=0 product_o equals operand×COEF in the same cycle, with no clock edge in between.
- R7: With REG_OUT=1 an active-low reset (rst_n=0) forces product_o to zero whatever the operand.
- R8: Operand 0 gives product 0, and operand 255 gives 255×COEF, which is the largest product.
- R9: Product bits [3:0] equal bits [3:0] of the low table's entry, because the shifted high entry adds nothing below bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| operand_i | input | 8 | Unsigned variable operand |
| product_o | output | 16 | operand_i × COEF |

## Verification
The registered variant's product is due one rising edge after its operand is driven. The combinational variant's product is due in the same cycle the operand changes. The bench drives every operand on a falling edge and queues the expected product. A monitor pops the queue 2 ns after the next rising edge, which is the first instant the registered result is valid and a moment when the combinational result is still stable. Both variants are swept through all 256 operands with different coefficients.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    // Number of digits needed to cover a word of the given width.
    function automatic int digit_count(input int word_w, input int digit_w);
        return (word_w + digit_w - 1) / digit_w;
    endfunction

endpackage

// File: rtl/lcm_digit_table.sv
module lcm_digit_table #(
    parameter int                  DIGIT_W = 4,
    parameter int                  COEF_W  = 8,
    parameter logic [COEF_W-1:0]   COEF    = 8'hAB,
    localparam int                 ENTRIES = 2 ** DIGIT_W,
    localparam int                 PART_W  = DIGIT_W + COEF_W
) (
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [PART_W-1:0]  entry_o
);

    localparam logic [PART_W-1:0] MAX_ENTRY = PART_W'(ENTRIES - 1) * PART_W'(COEF);

    logic [PART_W-1:0] table_q [ENTRIES];

    // Each entry is computed at elaboration from its index and the coefficient.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam logic [PART_W-1:0] VAL = PART_W'(e) * PART_W'(COEF);
        assign table_q[e] = VAL;
    end

    assign entry_o = table_q[digit_i];

    // R3: no looked-up entry may exceed the largest digit times the coefficient
    always_comb begin
        p_table_bound_r3: assert (entry_o <= MAX_ENTRY)
            else $error("table entry %0d above bound %0d", entry_o, MAX_ENTRY);
    end

endmodule

// File: rtl/lcm_shift_add.sv
module lcm_shift_add #(
    parameter int NDIG    = 2,
    parameter int DIGIT_W = 4,
    parameter int PART_W  = 12,
    parameter int PROD_W  = 16
) (
    input  logic [NDIG-1:0][PART_W-1:0] part_i,
    output logic [PROD_W-1:0]           sum_o
);

    always_comb begin
        sum_o = '0;
        for (int d = 0; d < NDIG; d++) begin
            sum_o = sum_o + (PROD_W'(part_i[d]) << (d * DIGIT_W));
        end
    end

    // R9: only the unshifted low partial reaches the lowest digit of the sum
    always_comb begin
        p_low_bits_r9: assert (sum_o[DIGIT_W-1:0] == part_i[0][DIGIT_W-1:0])
            else $error("low bits %0h differ from low partial %0h",
                        sum_o[DIGIT_W-1:0], part_i[0][DIGIT_W-1:0]);
    end

endmodule

// File: rtl/lcm_out_stage.sv
module lcm_out_stage #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o <= '0;
            end else begin
                q_o <= d_i;
            end
        end
    end else begin : g_wire
        assign q_o = d_i;
    end

endmodule

// File: rtl/lut_const_mult.sv
module lut_const_mult #(
    parameter int                OPERAND_W = 8,
    parameter int                COEF_W    = 8,
    parameter int                DIGIT_W   = 4,
    parameter logic [COEF_W-1:0] COEF      = 8'hAB,
    parameter bit                REG_OUT   = 1'b1,
    localparam int               PROD_W    = OPERAND_W + COEF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPERAND_W-1:0] operand_i,
    output logic [PROD_W-1:0]    product_o
);

    localparam int NDIG   = lcm_pkg::digit_count(OPERAND_W, DIGIT_W);
    localparam int PART_W = DIGIT_W + COEF_W;
    localparam int PAD_W  = NDIG * DIGIT_W;

    logic [PAD_W-1:0]             operand_pad;
    logic [NDIG-1:0][PART_W-1:0]  partials;
    logic [PROD_W-1:0]            sum;

    assign operand_pad = PAD_W'(operand_i);

    for (genvar d = 0; d < NDIG; d++) begin : g_digit
        lcm_digit_table #(
            .DIGIT_W (DIGIT_W),
            .COEF_W  (COEF_W),
            .COEF    (COEF)
        ) u_table (
            .digit_i (operand_pad[d*DIGIT_W +: DIGIT_W]),
            .entry_o (partials[d])
        );
    end

    lcm_shift_add #(
        .NDIG    (NDIG),
        .DIGIT_W (DIGIT_W),
        .PART_W  (PART_W),
        .PROD_W  (PROD_W)
    ) u_sum (
        .part_i (partials),
        .sum_o  (sum)
    );

    lcm_out_stage #(
        .W       (PROD_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sum),
        .q_o   (product_o)
    );

    // Behavioural reference product, used only by the checks below.
    logic [PROD_W-1:0] ref_prod;
    assign ref_prod = PROD_W'(operand_i) * PROD_W'(COEF);

    if (REG_OUT) begin : g_chk_reg
        // R5: product arrives one edge after its operand
        p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> product_o == $past(ref_prod))
            else $error("registered product mismatch");
    end else begin : g_chk_comb
        // R6: product tracks the operand within the cycle
        p_comb_r6: assert property (@(posedge clk) disable iff (!rst_n)
            product_o == ref_prod)
            else $error("combinational product mismatch");
    end

    // R2: with a zero low digit the sum is just the shifted high partials
    p_high_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_pad[DIGIT_W-1:0] == '0) |-> sum[DIGIT_W-1:0] == '0)
        else $error("low digit zero but low product bits set");

endmodule

// File: tb/test_lut_const_mult.sv
module test_lut_const_mult;

    localparam logic [7:0] COEF_A = 8'hAB;
    localparam logic [7:0] COEF_B = 8'hF7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  operand = 8'h55;
    logic [15:0] prod_a;
    logic [15:0] prod_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    lut_const_mult #(.COEF(COEF_A), .REG_OUT(1'b1)) i_lut_const_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_i (operand),
        .product_o (prod_a)
    );

    lut_const_mult #(.COEF(COEF_B), .REG_OUT(1'b0)) i_lut_const_mult_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_i (operand),
        .product_o (prod_b)
    );

    function automatic string tag_of(input logic [7:0] v);
        if (v == 8'h00 || v == 8'hFF) return "R8";
        if (v[7:4] == 4'h0)           return "R1/R3";
        if (v[3:0] == 4'h0)           return "R2";
        return "R4";
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: present one operand on a falling edge and queue what is due.
    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        operand = v;
        exp_q.push_back(v);
    endtask

    // Monitor: results are due after the following rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && exp_q.size() > 0) begin
                logic [7:0]  v;
                logic [15:0] ea;
                logic [15:0] eb;
                v  = exp_q.pop_front();
                ea = 16'(v) * 16'(COEF_A);
                eb = 16'(v) * 16'(COEF_B);
                check16({tag_of(v), " R5 coefA"}, prod_a, ea);
                check16({tag_of(v), " R6 coefB"}, prod_b, eb);
                check16("R9 low bits A", {12'h0, prod_a[3:0]},
                        {12'h0, 4'((16'(v[3:0]) * 16'(COEF_A)))});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: registered output held at zero during reset despite a nonzero operand
        check16("R7 reset", prod_a, 16'h0000);
        // R6: combinational variant already valid during reset
        check16("R6 comb in reset", prod_b, 16'(8'h55) * 16'(COEF_B));
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) begin
            drive(8'(i));
        end
        // R8 boundaries again in descending order, then a few patterns
        drive(8'hFF);
        drive(8'h00);
        drive(8'h0F);
        drive(8'hF0);
        drive(8'hA5);
        repeat (3) @(negedge clk);
        // R5: registered output holds between edges
        operand = 8'h3C;
        #1;
        check16("R5 hold", prod_a, 16'(8'hA5) * 16'(COEF_A));
        check16("R6 same cycle", prod_b, 16'(8'h3C) * 16'(COEF_B));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule